// File: doc/BRIEF.md
# PCI configuration access bridge

This block lets a host processor reach PCI configuration space through two CPU-visible resources: a 32-bit address register and a small data window. Software programs the address register with a target, then reads or writes the window with 1, 2 or 4 byte accesses. The bridge turns each window access into one downstream configuration request. The request carries a translated address, a length and write data, and a read returns data back to the CPU. The CPU access stalls until the downstream side completes.

A mode input selects how the address register is read. In generic mode, bit 31 acts as an enable. In translating mode, three address layouts are accepted and converted into one downstream format: enable-bit style, a type-1 style marked by bit 0, and a legacy style that carries the device slot as a one-hot bit. For the legacy style the one-hot bit is encoded into a slot number. For big-endian hosts, byte lanes can be swapped on the data path and on the address register, and a per-access input bypasses the swap on the register. A separate combinational swizzle maps the four interrupt pins of each slot onto four shared output lines.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the address register reads 0, `ds_valid` is low and `win_ack` is low.
- R2: A write to the address register is stored and read back unchanged when `swap_en` is 0 or `areg_noswap` is 1. When `swap_en` is 1 and `areg_noswap` is 0, both the write path and the read path reverse all four bytes. Writing and then reading on the swapped path therefore returns the written value, and reading on the no-swap path returns it byte-reversed.
- R3: In generic mode (`mode_xlate`=0) with register bit 31 set, a window access issues one request. Its address is the register value OR'd with offset bits 1:0, and its length, direction and write data follow the access. The length code is 3'b001 for 1 byte, 3'b010 for 2 bytes and 3'b100 for 4 bytes. Read data from downstream is returned on `win_rdata`.
- R4: In generic mode with register bit 31 clear, no request is issued. A write is dropped, and a read returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF, zero-extended.
- R5: In translating mode (`mode_xlate`=1) with bit 31 set, the request address is the register value OR'd with offset bits 1:0.
- R6: In translating mode with bit 31 clear and bit 0 set, the request address is register bits 31:3 followed by offset bits 2:0.
- R7: In translating mode with bits 31 and 0 both clear, the slot number is the position of the lowest set bit among register bits 31:11. The request address is then built as follows: bits 31:16 are zero, bits 15:11 hold the slot number, bits 10:8 copy register bits 10:8, bits 7:3 copy register bits 7:3, and bits 2:0 take offset bits 2:0.
- R8: In translating mode with bits 31 and 0 clear and no bit set in 31:11, no request is issued. A write is dropped, and a read returns all ones at the access width.
- R9: When `swap_en` is 1, write data sent downstream and read data returned to the CPU are converted. The conversion reverses all four bytes and then shifts right by 32 minus 8 times the byte length. A 1-byte value is therefore unchanged, and a 2-byte value has its two low bytes exchanged.
- R10: `ds_valid` stays high, with address, length, direction and data stable, until `ds_ready` is sampled high. The request address is captured when the access is accepted, so a later address-register write does not alter a request already in flight. `win_ack` is a one-cycle pulse that follows `ds_rvalid` for forwarded accesses.
- R11: Interrupt pin p of slot s drives output line (s + p) mod 4. Slot index k on `dev_int` is slot number SLOT_FIRST+k, its pin p (0..3) sits at bit 4k+p, and `irq_line[i]` stands for system interrupt line 27+i. With no pin asserted, all lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_xlate | input | 1 | 0 = generic enable-bit mode, 1 = translating mode |
| swap_en | input | 1 | Enable byte-lane conversion |
| areg_wr | input | 1 | Address register write strobe |
| areg_noswap | input | 1 | Bypass swap on address register access |
| areg_wdata | input | 32 | Address register write data |
| areg_rdata | output | 32 | Address register read data |
| win_req | input | 1 | Data window access request, held until `win_ack` |
| win_we | input | 1 | 1 = write, 0 = read |
| win_off | input | 3 | Byte offset within the data window |
| win_len | input | 3 | Length code 001/010/100 = 1/2/4 bytes |
| win_wdata | input | 32 | Window write data |
| win_ack | output | 1 | Access complete pulse |
| win_rdata | output | 32 | Window read data, valid with `win_ack` |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream request accepted |
| ds_we | output | 1 | Downstream request is a write |
| ds_addr | output | 32 | Translated configuration address |
| ds_len | output | 3 | Downstream length code |
| ds_wdata | output | 32 | Downstream write data |
| ds_rvalid | input | 1 | Downstream completion (read data or write done) |
| ds_rdata | input | 32 | Downstream read data |
| dev_int | input | 4*NUM_SLOTS | Per-slot interrupt pins, bit 4k+p |
| irq_line | output | 4 | Swizzled interrupt lines 27..30 |

## Verification
The two functions that can land in the same cycle are an address-register write and a data-window access that is waiting for downstream acceptance. The bench provokes this by stalling `ds_ready` for several cycles. While the request is pending, it reprograms the address register to a different target. It then judges the outcome by checking that the address seen when the request is accepted is still the one translated from the old register value. It also checks that the register reads back the new value once the access completes.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned OFF_W     = 3;
    localparam int unsigned LEN_W     = 3;
    localparam int unsigned NUM_LINES = 4;
    localparam int unsigned SLOT_LSB  = 11;
    localparam int unsigned SLOT_W    = 5;

    localparam logic [LEN_W-1:0] LEN_B1 = 3'b001;
    localparam logic [LEN_W-1:0] LEN_B2 = 3'b010;
    localparam logic [LEN_W-1:0] LEN_B4 = 3'b100;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_REQ,
        SEQ_WAIT,
        SEQ_ACK
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              we;
        logic [WORD_W-1:0] wdata;
    } cfg_req_t;

    // Full byte reversal, then right-justify to the access length.
    function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] v,
                                                    input logic [LEN_W-1:0] len);
        logic [WORD_W-1:0] rev;
        rev = {v[7:0], v[15:8], v[23:16], v[31:24]};
        case (len)
            LEN_B1:  return rev >> 24;
            LEN_B2:  return rev >> 16;
            default: return rev;
        endcase
    endfunction

    // All-ones pattern sized to the access.
    function automatic logic [WORD_W-1:0] ones_for(input logic [LEN_W-1:0] len);
        case (len)
            LEN_B1:  return 32'h0000_00FF;
            LEN_B2:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgb_addr_xlate.sv
module cfgb_addr_xlate
    import cfgb_pkg::*;
(
    input  logic [WORD_W-1:0] areg,
    input  logic [OFF_W-1:0]  off,
    input  logic              xlate,
    output logic              go,
    output logic [WORD_W-1:0] addr
);

    logic [SLOT_W-1:0] slot;
    logic              slot_found;

    // Lowest set bit among the one-hot slot field; scanning downward
    // leaves the lowest position as the final assignment.
    always_comb begin
        slot       = '0;
        slot_found = 1'b0;
        for (int b = WORD_W - 1; b >= int'(SLOT_LSB); b--) begin
            if (areg[b]) begin
                slot       = SLOT_W'(b);
                slot_found = 1'b1;
            end
        end
    end

    always_comb begin
        if (!xlate || areg[WORD_W-1]) begin
            go   = areg[WORD_W-1];
            addr = areg | {{(WORD_W-2){1'b0}}, off[1:0]};
        end else if (areg[0]) begin
            go   = 1'b1;
            addr = {areg[WORD_W-1:OFF_W], off};
        end else begin
            go   = slot_found;
            addr = {{(WORD_W-SLOT_LSB-SLOT_W){1'b0}}, slot, areg[SLOT_LSB-1:OFF_W], off};
        end
    end

endmodule

// File: rtl/cfgb_irq_swizzle.sv
module cfgb_irq_swizzle
    import cfgb_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 4,
    parameter int unsigned SLOT_FIRST = 11
) (
    input  logic [NUM_SLOTS*NUM_LINES-1:0] dev_int,
    output logic [NUM_LINES-1:0]           irq_line
);

    localparam int unsigned PINS = NUM_LINES;

    for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
        logic [NUM_SLOTS*PINS-1:0] hit;
        for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
            for (genvar p = 0; p < PINS; p++) begin : g_pin
                if (((SLOT_FIRST + k + p) % NUM_LINES) == li) begin : g_on
                    assign hit[k*PINS+p] = dev_int[k*PINS+p];
                end else begin : g_off
                    assign hit[k*PINS+p] = 1'b0;
                end
            end
        end
        assign irq_line[li] = |hit;
    end

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cfgb_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 4,
    parameter int unsigned SLOT_FIRST = 11
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           mode_xlate,
    input  logic                           swap_en,
    input  logic                           areg_wr,
    input  logic                           areg_noswap,
    input  logic [31:0]                    areg_wdata,
    output logic [31:0]                    areg_rdata,
    input  logic                           win_req,
    input  logic                           win_we,
    input  logic [2:0]                     win_off,
    input  logic [2:0]                     win_len,
    input  logic [31:0]                    win_wdata,
    output logic                           win_ack,
    output logic [31:0]                    win_rdata,
    output logic                           ds_valid,
    input  logic                           ds_ready,
    output logic                           ds_we,
    output logic [31:0]                    ds_addr,
    output logic [2:0]                     ds_len,
    output logic [31:0]                    ds_wdata,
    input  logic                           ds_rvalid,
    input  logic [31:0]                    ds_rdata,
    input  logic [NUM_SLOTS*4-1:0]         dev_int,
    output logic [3:0]                     irq_line
);

    seq_state_t        state;
    cfg_req_t          req_q;
    logic [WORD_W-1:0] areg_q;
    logic [WORD_W-1:0] rdata_q;
    logic              xl_go;
    logic [WORD_W-1:0] xl_addr;
    logic              areg_swapped;

    assign areg_swapped = swap_en && !areg_noswap;

    cfgb_addr_xlate u_xlate (
        .areg  (areg_q),
        .off   (win_off),
        .xlate (mode_xlate),
        .go    (xl_go),
        .addr  (xl_addr)
    );

    cfgb_irq_swizzle #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_FIRST (SLOT_FIRST)
    ) u_swz (
        .dev_int  (dev_int),
        .irq_line (irq_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            areg_q  <= '0;
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (areg_wr) begin
                areg_q <= areg_swapped ? lane_swap(areg_wdata, LEN_B4) : areg_wdata;
            end
            case (state)
                SEQ_IDLE: begin
                    if (win_req) begin
                        if (xl_go) begin
                            req_q.addr  <= xl_addr;
                            req_q.len   <= win_len;
                            req_q.we    <= win_we;
                            req_q.wdata <= swap_en ? lane_swap(win_wdata, win_len) : win_wdata;
                            state       <= SEQ_REQ;
                        end else begin
                            rdata_q <= win_we ? '0 : ones_for(win_len);
                            state   <= SEQ_ACK;
                        end
                    end
                end
                SEQ_REQ: begin
                    if (ds_ready) state <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (ds_rvalid) begin
                        if (req_q.we)     rdata_q <= '0;
                        else if (swap_en) rdata_q <= lane_swap(ds_rdata, req_q.len);
                        else              rdata_q <= ds_rdata;
                        state <= SEQ_ACK;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign areg_rdata = areg_swapped ? lane_swap(areg_q, LEN_B4) : areg_q;
    assign ds_valid   = (state == SEQ_REQ);
    assign ds_we      = req_q.we;
    assign ds_addr    = req_q.addr;
    assign ds_len     = req_q.len;
    assign ds_wdata   = req_q.wdata;
    assign win_ack    = (state == SEQ_ACK);
    assign win_rdata  = rdata_q;

endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mode_xlate,
    input logic                   ds_valid,
    input logic                   ds_ready,
    input logic                   ds_we,
    input logic [31:0]            ds_addr,
    input logic [2:0]             ds_len,
    input logic [31:0]            ds_wdata,
    input logic                   win_ack,
    input logic [NUM_SLOTS*4-1:0] dev_int,
    input logic [3:0]             irq_line
);

    AST_DS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ds_valid && !ds_ready |=> ds_valid && $stable(ds_addr) && $stable(ds_len)
                                  && $stable(ds_we) && $stable(ds_wdata)); // R10

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ds_valid |-> $countones(ds_len) == 1); // R3

    AST_GEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        ds_valid && !mode_xlate |-> ds_addr[31]); // R4

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        win_ack |=> !win_ack); // R10

    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(win_ack && ds_valid)); // R10

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        dev_int == '0 |-> irq_line == 4'b0000); // R11

endmodule

bind cfg_access_bridge cfgb_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_xlate (mode_xlate),
    .ds_valid   (ds_valid),
    .ds_ready   (ds_ready),
    .ds_we      (ds_we),
    .ds_addr    (ds_addr),
    .ds_len     (ds_len),
    .ds_wdata   (ds_wdata),
    .win_ack    (win_ack),
    .dev_int    (dev_int),
    .irq_line   (irq_line)
);

// File: tb/cfg_access_bridge_bench.sv
`timescale 1ns/1ps
module cfg_access_bridge_bench;

    localparam int NS = 4;
    localparam int SF = 11;

    logic clk = 1'b0;
    logic rst;
    logic mode_xlate, swap_en, areg_wr, areg_noswap;
    logic [31:0] areg_wdata, areg_rdata;
    logic win_req, win_we;
    logic [2:0] win_off, win_len;
    logic [31:0] win_wdata, win_rdata;
    logic win_ack;
    logic ds_valid, ds_ready, ds_we, ds_rvalid;
    logic [31:0] ds_addr, ds_wdata, ds_rdata;
    logic [2:0] ds_len;
    logic [NS*4-1:0] dev_int;
    logic [3:0] irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int ds_cnt = 0;
    int rsp_wait = 0;
    logic [31:0] rsp_data = 32'h0;
    logic [31:0] cap_addr, cap_wdata, rdy_addr;
    logic [2:0]  cap_len;
    logic        cap_we;

    always #5 clk = ~clk;

    cfg_access_bridge #(.NUM_SLOTS(NS), .SLOT_FIRST(SF)) u_cfg_access_bridge (
        .clk(clk), .rst(rst), .mode_xlate(mode_xlate), .swap_en(swap_en),
        .areg_wr(areg_wr), .areg_noswap(areg_noswap), .areg_wdata(areg_wdata),
        .areg_rdata(areg_rdata), .win_req(win_req), .win_we(win_we),
        .win_off(win_off), .win_len(win_len), .win_wdata(win_wdata),
        .win_ack(win_ack), .win_rdata(win_rdata), .ds_valid(ds_valid),
        .ds_ready(ds_ready), .ds_we(ds_we), .ds_addr(ds_addr), .ds_len(ds_len),
        .ds_wdata(ds_wdata), .ds_rvalid(ds_rvalid), .ds_rdata(ds_rdata),
        .dev_int(dev_int), .irq_line(irq_line)
    );

    function automatic logic [31:0] ref_swap(input logic [31:0] v, input int nbytes);
        logic [31:0] r;
        r = {v[7:0], v[15:8], v[23:16], v[31:24]};
        return r >> (32 - 8 * nbytes);
    endfunction

    function automatic logic [2:0] code_of(input int nbytes);
        return (nbytes == 1) ? 3'b001 : (nbytes == 2) ? 3'b010 : 3'b100;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Downstream responder model.
    initial begin
        ds_ready = 0; ds_rvalid = 0; ds_rdata = 0;
        forever begin
            @(negedge clk);
            if (ds_valid) begin
                cap_addr = ds_addr; cap_len = ds_len; cap_we = ds_we; cap_wdata = ds_wdata;
                ds_cnt++;
                repeat (rsp_wait) @(negedge clk);
                rdy_addr = ds_addr;
                ds_ready = 1;
                @(negedge clk);
                ds_ready = 0;
                ds_rvalid = 1;
                ds_rdata = rsp_data;
                @(negedge clk);
                ds_rvalid = 0;
            end
        end
    end

    task automatic set_areg(input logic [31:0] v, input logic nosw);
        @(negedge clk);
        areg_wr = 1; areg_wdata = v; areg_noswap = nosw;
        @(negedge clk);
        areg_wr = 0; areg_noswap = 1;
    endtask

    task automatic cpu_access(input logic we, input logic [2:0] off, input int nbytes,
                              input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        win_req = 1; win_we = we; win_off = off; win_len = code_of(nbytes); win_wdata = wd;
        do @(negedge clk); while (!win_ack);
        rd = win_rdata;
        win_req = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 areg", areg_rdata, 32'h0);
        chk("R1 ds_valid", {31'b0, ds_valid}, 32'h0);
        chk("R1 win_ack", {31'b0, win_ack}, 32'h0);
    endtask

    task automatic t_areg();
        set_areg(32'hDEADBEEF, 1);
        chk("R2 readback", areg_rdata, 32'hDEADBEEF);
        swap_en = 1;
        set_areg(32'h11223344, 0);
        areg_noswap = 0; #1;
        chk("R2 swapped path readback", areg_rdata, 32'h11223344);
        areg_noswap = 1; #1;
        chk("R2 noswap path raw", areg_rdata, 32'h44332211);
        swap_en = 0;
    endtask

    task automatic t_generic_on();
        logic [31:0] rd;
        int n0;
        mode_xlate = 0;
        set_areg(32'h80001230, 1);
        n0 = ds_cnt;
        cpu_access(1, 3'd3, 1, 32'h000000A5, rd);
        chk("R3 one request", ds_cnt - n0, 1);
        chk("R3 addr", cap_addr, 32'h80001233);
        chk("R3 len", {29'b0, cap_len}, 32'h1);
        chk("R3 we", {31'b0, cap_we}, 32'h1);
        chk("R3 wdata", cap_wdata, 32'hA5);
        rsp_data = 32'hCAFEF00D;
        cpu_access(0, 3'd0, 4, 32'h0, rd);
        chk("R3 read addr", cap_addr, 32'h80001230);
        chk("R3 read data", rd, 32'hCAFEF00D);
    endtask

    task automatic t_generic_off();
        logic [31:0] rd;
        int n0;
        set_areg(32'h00001230, 1);
        n0 = ds_cnt;
        cpu_access(1, 3'd0, 4, 32'h12345678, rd);
        chk("R4 write dropped", ds_cnt - n0, 0);
        for (int i = 0; i < 3; i++) begin
            int nb = 1 << i;
            cpu_access(0, 3'd1, nb, 32'h0, rd);
            chk("R4 ones read", rd, (nb == 4) ? 32'hFFFFFFFF : ((32'h1 << (8 * nb)) - 1));
        end
        chk("R4 no request", ds_cnt - n0, 0);
    endtask

    task automatic t_xlate();
        logic [31:0] rd, r;
        int n0;
        mode_xlate = 1;
        rsp_data = 32'h0;
        set_areg(32'h8000ABC4, 1);
        cpu_access(0, 3'd6, 2, 32'h0, rd);
        chk("R5 addr", cap_addr, 32'h8000ABC4 | 32'h2);
        set_areg(32'h00ABCDE5, 1);
        cpu_access(0, 3'd2, 1, 32'h0, rd);
        chk("R6 addr", cap_addr, 32'h00ABCDE2);
        r = (32'h1 << 13) | (32'h5 << 8) | 32'h48;
        set_areg(r, 1);
        cpu_access(1, 3'd6, 4, 32'h77, rd);
        chk("R7 addr slot 13", cap_addr, (32'd13 << 11) | (32'h5 << 8) | 32'h48 | 32'h6);
        r = (32'h1 << 20) | (32'h1 << 16) | (32'h2 << 8) | 32'hF8;
        set_areg(r, 1);
        cpu_access(0, 3'd1, 1, 32'h0, rd);
        chk("R7 addr lowest bit 16", cap_addr, (32'd16 << 11) | (32'h2 << 8) | 32'hF8 | 32'h1);
        set_areg(32'h00000754, 1);
        n0 = ds_cnt;
        cpu_access(1, 3'd0, 4, 32'h1, rd);
        cpu_access(0, 3'd0, 2, 32'h0, rd);
        chk("R8 ones read", rd, 32'h0000FFFF);
        chk("R8 no request", ds_cnt - n0, 0);
        mode_xlate = 0;
    endtask

    task automatic t_swap();
        logic [31:0] rd;
        set_areg(32'h80000010, 1);
        swap_en = 1;
        cpu_access(1, 3'd0, 2, 32'h00001234, rd);
        chk("R9 wdata len2", cap_wdata, ref_swap(32'h00001234, 2));
        cpu_access(1, 3'd0, 4, 32'h11223344, rd);
        chk("R9 wdata len4", cap_wdata, ref_swap(32'h11223344, 4));
        cpu_access(1, 3'd0, 1, 32'h0000005A, rd);
        chk("R9 wdata len1", cap_wdata, 32'h5A);
        rsp_data = 32'h0000ABCD;
        cpu_access(0, 3'd0, 2, 32'h0, rd);
        chk("R9 rdata len2", rd, 32'h0000CDAB);
        swap_en = 0;
    endtask

    task automatic t_collide();
        logic [31:0] rd;
        set_areg(32'h80004400, 1);
        rsp_wait = 3;
        rsp_data = 32'h0BADF00D;
        fork
            cpu_access(0, 3'd2, 4, 32'h0, rd);
            begin
                @(negedge clk); @(negedge clk); @(negedge clk);
                areg_wr = 1; areg_wdata = 32'h80009900; areg_noswap = 1;
                @(negedge clk);
                areg_wr = 0;
            end
        join
        rsp_wait = 0;
        chk("R10 addr at accept", rdy_addr, 32'h80004402);
        chk("R10 addr first seen", cap_addr, 32'h80004402);
        chk("R10 read data", rd, 32'h0BADF00D);
        chk("R10 register updated", areg_rdata, 32'h80009900);
        chk("R10 ack dropped", {31'b0, win_ack}, 32'h0);
    endtask

    task automatic t_irq();
        dev_int = '0; #1;
        chk("R11 quiet", {28'b0, irq_line}, 32'h0);
        for (int k = 0; k < NS; k++) begin
            for (int p = 0; p < 4; p++) begin
                dev_int = '0;
                dev_int[k*4+p] = 1'b1;
                #1;
                chk("R11 swizzle", {28'b0, irq_line}, 32'h1 << ((SF + k + p) % 4));
            end
        end
        dev_int = '0;
    endtask

    initial begin
        rst = 1; mode_xlate = 0; swap_en = 0; areg_wr = 0; areg_noswap = 1;
        areg_wdata = 0; win_req = 0; win_we = 0; win_off = 0; win_len = 3'b100;
        win_wdata = 0; dev_int = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_areg();
        t_generic_on();
        t_generic_off();
        t_xlate();
        t_swap();
        t_collide();
        t_irq();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule